// File: doc/BRIEF.md
# Comma-Aligned Serial Character Framer

This block sits behind a clock-recovery stage and turns a serial bit stream, arriving one bit per clock, into 10-bit transmission characters. A ten-bit shift window collects the stream. A bit counter marks where one character ends and the next begins, and the block presents each finished character on a parallel output together with a one-cycle strobe.

The block finds the character boundary from the comma held in the K28.5 special character. The comma is the 7-bit run 0011111 or its inverse 1100000, which covers both running-disparity forms. The boundary moves only while the reframe-enable input is high. Once the link is framed, the system can drop reframe-enable so that a comma-like pattern produced by a bit error cannot shift the framing. An active-low ready flag falls once a comma has fixed the boundary and stays low until the next reset.

Top module: `comma_framer`

## Requirements
- R1: During and directly after a synchronous reset, `char_valid` is 0, `ready_n` is 1 and `char_out` is all zeros.
- R2: Once a boundary is set, `char_valid` pulses for one cycle every 10 clocks. `char_out` changes only in a cycle where `char_valid` is 1.
- R3: Serial order is a,b,c,d,e,i,f,g,h,j, with bit a arriving first. In `char_out`, bit a appears at bit 9 and bit j at bit 0.
- R4: A comma is bits a..g equal to 0011111 or to 1100000. If such a comma completes its character (bit j is sampled) while `reframe_en` is 1, `char_valid` is 1 in the next cycle and `char_out` then holds that full character, for example 0011111010 or 1100000101.
- R5: `ready_n` stays 1 after reset until the first comma alignment. It is 0 from the cycle of that comma's strobe onward.
- R6: While `reframe_en` is 0, a comma at a different offset changes neither the strobe timing nor the character slicing.
- R7: A comma that arrives at the current boundary with `reframe_en` at 1 leaves the 10-clock strobe rhythm unbroken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Serial bit, bit a of each character first |
| reframe_en | input | 1 | Allows a detected comma to move the boundary |
| char_out | output | 10 | Aligned character, bit a at bit 9 |
| char_valid | output | 1 | One-cycle strobe per character |
| ready_n | output | 1 | Low once a comma has set the boundary |

## Verification
The stream opens with a run of zeros. This shows that no false alignment happens and that ready stays high. Next comes a negative-disparity comma followed by data, which checks the first alignment and the bit order. A positive-disparity comma at the same offset then checks that the rhythm holds. The stream is then slipped by three bits and a comma is sent with reframe disabled, which separates a block that ignores the comma from one that realigns. Finally the stream is slipped by four bits and a positive-disparity comma is sent with reframe enabled, which proves the boundary really moves. A scoreboard model slices the sent bits at the boundary it expects and checks the value and timing of every strobe.

// File: rtl/comma_pkg.sv
package comma_pkg;
  localparam int CHAR_W  = 10;
  localparam int COMMA_W = 7;
  localparam logic [COMMA_W-1:0] COMMA_NEG = 7'b0011111;
  localparam logic [COMMA_W-1:0] COMMA_POS = 7'b1100000;
endpackage

// File: rtl/comma_shifter.sv
module comma_shifter #(
  parameter int W = comma_pkg::CHAR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_in,
  output logic [W-1:0] win_next
);
  logic [W-1:0] win_q;

  assign win_next = {win_q[W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else     win_q <= win_next;
  end
endmodule

// File: rtl/comma_detect.sv
module comma_detect #(
  parameter int W  = comma_pkg::CHAR_W,
  parameter int CW = comma_pkg::COMMA_W
) (
  input  logic [W-1:0] cand,
  output logic         hit
);
  logic [CW-1:0] head;

  assign head = cand[W-1 -: CW];
  assign hit  = (head == comma_pkg::COMMA_NEG) || (head == comma_pkg::COMMA_POS);
endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl #(
  parameter int W = comma_pkg::CHAR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reframe_en,
  input  logic         hit,
  input  logic [W-1:0] cand,
  output logic [W-1:0] char_out,
  output logic         char_valid,
  output logic         ready_n
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             realign;

  assign realign = reframe_en && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      char_out   <= '0;
      char_valid <= 1'b0;
      ready_n    <= 1'b1;
    end else begin
      char_valid <= 1'b0;
      if (realign) begin
        cnt_q      <= '0;
        char_out   <= cand;
        char_valid <= 1'b1;
        ready_n    <= 1'b0;
      end else if (cnt_q == LAST) begin
        cnt_q      <= '0;
        char_out   <= cand;
        char_valid <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst) cnt_q <= LAST);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !char_valid |-> $stable(char_out));
  p_ready_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    !ready_n |=> !ready_n);
endmodule

// File: rtl/comma_framer.sv
module comma_framer #(
  parameter int W  = comma_pkg::CHAR_W,
  parameter int CW = comma_pkg::COMMA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         serial_in,
  input  logic         reframe_en,
  output logic [W-1:0] char_out,
  output logic         char_valid,
  output logic         ready_n
);
  logic [W-1:0] win_next;
  logic         comma_hit;

  comma_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .bit_in(serial_in), .win_next(win_next)
  );

  comma_detect #(.W(W), .CW(CW)) u_det (
    .cand(win_next), .hit(comma_hit)
  );

  framer_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .reframe_en(reframe_en), .hit(comma_hit),
    .cand(win_next), .char_out(char_out), .char_valid(char_valid),
    .ready_n(ready_n)
  );

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (ready_n && !char_valid && char_out == '0));
  p_align_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    (reframe_en && comma_hit) |=> (char_valid && !ready_n && char_out == $past(win_next)));
  p_ready_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_n) |-> $past(reframe_en && comma_hit));
endmodule

// File: tb/comma_framer_tb_top.sv
module comma_framer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] K_NEG = 10'b0011111010;
  localparam logic [9:0] K_POS = 10'b1100000101;
  localparam logic [9:0] DA = 10'b1010101010;
  localparam logic [9:0] DB = 10'b0110101001;
  localparam logic [9:0] DC = 10'b1001010110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serial_in = 1'b0;
  logic reframe_en = 1'b0;
  logic [9:0] char_out;
  logic char_valid;
  logic ready_n;

  int n_chk = 0;
  int n_fail = 0;
  logic [9:0] exp_q[$];
  logic [9:0] hist = '0;
  int nbits = 0;
  int bnd = 0;
  bit aligned = 1'b0;
  bit want_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  comma_framer dut_i (
    .clk(clk), .rst(rst), .serial_in(serial_in), .reframe_en(reframe_en),
    .char_out(char_out), .char_valid(char_valid), .ready_n(ready_n)
  );

  task automatic check(input bit ok, input string req, input logic [9:0] act, input logic [9:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, expv);
    end
  endtask

  // Driver: one bit per negedge; model slices at the expected boundary
  task automatic send_bit(input logic b, input bit comma_end);
    @(negedge clk);
    if (want_ready) begin
      check(ready_n == 1'b0, "R5 ready low after alignment", {9'b0, ready_n}, 10'd0);
      want_ready = 1'b0;
    end
    serial_in = b;
    hist = {hist[8:0], b};
    nbits++;
    if (comma_end && reframe_en) begin
      bnd = nbits;
      if (!aligned) want_ready = 1'b1;
      aligned = 1'b1;
      exp_q.push_back(hist);
    end else if (aligned && ((nbits - bnd) % 10 == 0)) begin
      exp_q.push_back(hist);
    end
  endtask

  task automatic send_char(input logic [9:0] c, input bit is_comma);
    for (int i = 9; i >= 0; i--) send_bit(c[i], is_comma && (i == 0));
  endtask

  // Monitor: compare every aligned strobe against the scoreboard
  always @(negedge clk) begin
    if (!rst && char_valid && !ready_n) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R6 unexpected strobe", char_out, 10'bx);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        check(char_out == e, "R3/R4/R6/R7 character", char_out, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(char_valid == 1'b0, "R1 strobe idle in reset", {9'b0, char_valid}, 10'd0);
    check(ready_n == 1'b1, "R1 ready high in reset", {9'b0, ready_n}, 10'd1);
    @(negedge clk) rst = 1'b0;
    check(char_out == 10'd0, "R1 char_out zero after reset", char_out, 10'd0);
    // Phase: initial alignment on RD- comma, then RD+ at same offset (R4, R7)
    reframe_en = 1'b1;
    for (int i = 0; i < 7; i++) send_bit(1'b0, 1'b0);
    check(ready_n == 1'b1, "R5 ready high before comma", {9'b0, ready_n}, 10'd1);
    send_char(K_NEG, 1'b1);
    send_char(DA, 1'b0);
    send_char(DB, 1'b0);
    send_char(K_POS, 1'b1);
    send_char(DC, 1'b0);
    // Phase: slip 3 bits, comma with reframe disabled must not move (R6)
    @(negedge clk) ;
    reframe_en = 1'b0;
    hist = {hist[8:0], serial_in};
    nbits++;
    if ((nbits - bnd) % 10 == 0) exp_q.push_back(hist);
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b1);
    send_char(K_NEG, 1'b1);
    send_char(DA, 1'b0);
    send_char(DB, 1'b0);
    // Phase: slip 4 bits, comma with reframe enabled realigns (R4)
    reframe_en = 1'b1;
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    send_char(K_POS, 1'b1);
    send_char(DC, 1'b0);
    send_char(DA, 1'b0);
    send_char(DB, 1'b0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all expected strobes seen", 10'(exp_q.size()), 10'd0);
    check(ready_n == 1'b0, "R5 ready stays low", {9'b0, ready_n}, 10'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule